// File: doc/BRIEF.md
# Down-counting tick timer

This block is a periodic tick source. A 24-bit counter counts down from a value that software programs and reloads that value after each expiry, so the expiry events come at a fixed rate. Each count step is taken on every core clock or only on the cycles where an external reference tick input is high. A control bit picks which. The reference tick is a one-cycle enable in the core clock domain, and the block uses no second clock.

Each step from 1 to 0 sets a sticky zero-reached flag in the control word. Reading the control word clears the flag. When the interrupt enable is set, the same step also raises a one-cycle interrupt request. Software can force the count to zero by writing the current-value location. That write clears the flag and raises no interrupt. The next active tick then loads the reload value.

Inside, a three-state counter machine (HALT, RUN, ZERO) and a two-state flag machine (CLEAR, SET) sit behind a small register decoder. The counter transitions are: HALT→RUN or HALT→ZERO on enable, chosen by whether the count is nonzero. RUN→ZERO on the step from 1 to 0. ZERO→RUN on an active tick with a nonzero reload. ZERO→ZERO on an active tick with a zero reload. RUN or ZERO→HALT when the enable is cleared. Any state goes to ZERO (enabled) or HALT (disabled) on a current-value write. The flag transitions are: CLEAR→SET on an expiry step. SET→CLEAR on a control read or a current-value write.

Top module: `dtick_timer`

## Requirements
- R1: After reset the control word (offset 0x10), the reload value (offset 0x14) and the current count (offset 0x18) all read 0, and the interrupt request is low.
- R2: While control bit 0 (enable) is 0 the count does not change, except through a current-value write. Clearing the enable stops counting from the second clock after the write.
- R3: With the enable and control bit 2 (core clock) both set, the count takes its first step on the second clock after the enabling write. It then falls by one each clock, and on the clock after reaching 0 it loads the reload value. The period is reload+1 clocks.
- R4: With control bit 2 clear, the count steps only on clocks where the reference tick input is 1, and holds on all other clocks.
- R5: Control bit 16 (zero flag) is set by a count step from 1 to 0. It stays set until the control word is read, and that read returns the flag as 1 and then clears it. A set and a read on the same clock leave the flag set.
- R6: A step from 1 to 0 with control bit 1 (interrupt enable) set drives the interrupt request high for exactly one clock. This is the same clock on which the flag first reads 1. With bit 1 clear, no request is raised.
- R7: A write of any data to offset 0x18 sets the count to 0 and clears the flag, and it raises no interrupt request. The next active tick loads the reload value.
- R8: Control bits 31:17 and 15:3 read as 0, and writes to them, including bit 16, have no effect. Reload bits 31:24 read as 0. Addresses other than 0x10, 0x14 and 0x18 read as 0.
- R9: With a reload value of 0 the running count stays at 0, with no flag set and no interrupt request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | One-cycle reference tick enable, core clock domain |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the accessed register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as a read strobe |
| tick_irq_o | output | 1 | One-cycle tick interrupt request |

## Verification
A counter state machine left in the wrong state shows up as a count that holds or moves out of turn. Reads of offset 0x18 at known cycle offsets from the enabling write catch this within one step. An expiry counted too early or too late moves the flag bit and the interrupt pulse by whole clocks, so the bench counts pulses over windows whose length is set by the period. A flag machine that drops or keeps its state by mistake is caught by back-to-back control reads, including the read that lands on the clock of the expiry. A stuck interrupt line is caught on its second high clock.

// File: rtl/dtick_pkg.sv
`timescale 1ns/1ps
package dtick_pkg;
    localparam int DATA_W      = 32;
    localparam int NUM_REGS    = 3;
    localparam int IDX_CTRL    = 0;
    localparam int IDX_RELOAD  = 1;
    localparam int IDX_CURRENT = 2;

    // control word bit positions
    localparam int BIT_EN    = 0;
    localparam int BIT_INTEN = 1;
    localparam int BIT_SRC   = 2;
    localparam int BIT_FLAG  = 16;

    typedef struct packed {
        logic src_core;
        logic inten;
        logic en;
    } ctrl_t;

    typedef enum logic [1:0] {
        CNT_HALT = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_ZERO = 2'd2
    } cnt_state_e;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flag_state_e;

    function automatic logic [7:0] reg_offset(input int idx);
        case (idx)
            IDX_CTRL:   return 8'h10;
            IDX_RELOAD: return 8'h14;
            default:    return 8'h18;
        endcase
    endfunction
endpackage

// File: rtl/dtick_regs.sv
`timescale 1ns/1ps
module dtick_regs
    import dtick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ctrl_wr_i,
    input  logic                reload_wr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output ctrl_t               ctrl_o,
    output logic [CNT_W-1:0]    reload_o
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_o   <= '0;
            reload_o <= '0;
        end else begin
            if (ctrl_wr_i) begin
                ctrl_o.en       <= wdata_i[BIT_EN];
                ctrl_o.inten    <= wdata_i[BIT_INTEN];
                ctrl_o.src_core <= wdata_i[BIT_SRC];
            end
            if (reload_wr_i) begin
                reload_o <= wdata_i[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dtick_counter.sv
`timescale 1ns/1ps
module dtick_counter
    import dtick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             src_core_i,
    input  logic             ref_tick_i,
    input  logic             cur_clr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             active;
    logic             hit;

    assign active = src_core_i | ref_tick_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= CNT_HALT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (cur_clr_i) begin
            cnt_d = '0;
            st_d  = en_i ? CNT_ZERO : CNT_HALT;
        end else begin
            unique case (st_q)
                CNT_HALT: begin
                    if (en_i) begin
                        st_d = (cnt_q == '0) ? CNT_ZERO : CNT_RUN;
                    end
                end
                CNT_RUN: begin
                    if (!en_i) begin
                        st_d = CNT_HALT;
                    end else if (active) begin
                        if (cnt_q == ONE) begin
                            cnt_d = '0;
                            hit   = 1'b1;
                            st_d  = CNT_ZERO;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                CNT_ZERO: begin
                    if (!en_i) begin
                        st_d = CNT_HALT;
                    end else if (active) begin
                        cnt_d = reload_i;
                        st_d  = (reload_i == '0) ? CNT_ZERO : CNT_RUN;
                    end
                end
                default: st_d = CNT_HALT;
            endcase
        end
    end

    assign cnt_o = cnt_q;
    assign hit_o = hit;
endmodule

// File: rtl/dtick_flag.sv
`timescale 1ns/1ps
module dtick_flag
    import dtick_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic inten_i,
    input  logic rd_clr_i,
    input  logic wr_clr_i,
    output logic flag_o,
    output logic irq_o
);
    flag_state_e st_q, st_d;
    logic        irq_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= FLG_CLEAR;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= hit_i & inten_i;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_CLEAR: if (hit_i) st_d = FLG_SET;
            FLG_SET:   if (!hit_i && (rd_clr_i || wr_clr_i)) st_d = FLG_CLEAR;
            default:   st_d = FLG_CLEAR;
        endcase
    end

    assign flag_o = (st_q == FLG_SET);
    assign irq_o  = irq_q;
endmodule

// File: rtl/dtick_bus.sv
`timescale 1ns/1ps
module dtick_bus
    import dtick_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24
) (
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  ctrl_t             ctrl_i,
    input  logic              flag_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              ctrl_wr_o,
    output logic              reload_wr_o,
    output logic              cur_wr_o,
    output logic              ctrl_rd_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [NUM_REGS-1:0] hit;
    logic                rd;
    logic                wr;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign hit[g] = (addr_i == ADDR_W'(reg_offset(g)));
    end

    assign rd = sel_i & ~we_i;
    assign wr = sel_i &  we_i;

    assign ctrl_wr_o   = wr & hit[IDX_CTRL];
    assign reload_wr_o = wr & hit[IDX_RELOAD];
    assign cur_wr_o    = wr & hit[IDX_CURRENT];
    assign ctrl_rd_o   = rd & hit[IDX_CTRL];

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            if (hit[IDX_CTRL]) begin
                rdata_o[BIT_EN]    = ctrl_i.en;
                rdata_o[BIT_INTEN] = ctrl_i.inten;
                rdata_o[BIT_SRC]   = ctrl_i.src_core;
                rdata_o[BIT_FLAG]  = flag_i;
            end else if (hit[IDX_RELOAD]) begin
                rdata_o[CNT_W-1:0] = reload_i;
            end else if (hit[IDX_CURRENT]) begin
                rdata_o[CNT_W-1:0] = cnt_i;
            end
        end
    end
endmodule

// File: rtl/dtick_timer.sv
`timescale 1ns/1ps
module dtick_timer
    import dtick_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              tick_irq_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_val;
    logic             flag_val;
    logic             hit;
    logic             ctrl_wr;
    logic             reload_wr;
    logic             cur_wr;
    logic             ctrl_rd;

    dtick_bus #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) bus_i (
        .sel_i       (bus_sel_i),
        .we_i        (bus_we_i),
        .addr_i      (bus_addr_i),
        .ctrl_i      (ctrl_q),
        .flag_i      (flag_val),
        .reload_i    (reload_q),
        .cnt_i       (cnt_val),
        .ctrl_wr_o   (ctrl_wr),
        .reload_wr_o (reload_wr),
        .cur_wr_o    (cur_wr),
        .ctrl_rd_o   (ctrl_rd),
        .rdata_o     (bus_rdata_o)
    );

    dtick_regs #(.CNT_W(CNT_W)) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctrl_wr_i   (ctrl_wr),
        .reload_wr_i (reload_wr),
        .wdata_i     (bus_wdata_i),
        .ctrl_o      (ctrl_q),
        .reload_o    (reload_q)
    );

    dtick_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (ctrl_q.en),
        .src_core_i (ctrl_q.src_core),
        .ref_tick_i (ref_tick_i),
        .cur_clr_i  (cur_wr),
        .reload_i   (reload_q),
        .cnt_o      (cnt_val),
        .hit_o      (hit)
    );

    dtick_flag flag_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hit_i    (hit),
        .inten_i  (ctrl_q.inten),
        .rd_clr_i (ctrl_rd),
        .wr_clr_i (cur_wr),
        .flag_o   (flag_val),
        .irq_o    (tick_irq_o)
    );
endmodule

// File: rtl/dtick_timer_chk.sv
`timescale 1ns/1ps
module dtick_timer_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_rdata_o,
    input logic              tick_irq_o,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              flag_val,
    input logic              ctrl_en,
    input logic              ctrl_inten,
    input logic              cur_wr
);
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_en && !cur_wr) |=> (cnt_val == $past(cnt_val))); // R2

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_irq_o |=> !tick_irq_o); // R6

    AST_IRQ_NEEDS_INTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_irq_o |-> $past(ctrl_inten)); // R6

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_irq_o |-> flag_val); // R5

    AST_CUR_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_wr |=> (cnt_val == '0 && !flag_val && !tick_irq_o)); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_we_i && bus_addr_i == ADDR_W'(8'h10))
            |-> ((bus_rdata_o & 32'hFFFE_FFF8) == 32'h0)); // R8
endmodule

bind dtick_timer dtick_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .tick_irq_o  (tick_irq_o),
    .cnt_val     (cnt_val),
    .flag_val    (flag_val),
    .ctrl_en     (ctrl_q.en),
    .ctrl_inten  (ctrl_q.inten),
    .cur_wr      (cur_wr)
);

// File: tb/dtick_timer_tb_top.sv
`timescale 1ns/100ps
module dtick_timer_tb_top;
    localparam int AW = 8;
    localparam int CW = 24;
    localparam logic [AW-1:0] A_CTRL = 8'h10;
    localparam logic [AW-1:0] A_RLD  = 8'h14;
    localparam logic [AW-1:0] A_CUR  = 8'h18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    always #2 clk = ~clk;

    dtick_timer #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ref_tick_i  (ref_tick),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tick_irq_o  (irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   fails = 0;
    int   irq_cnt = 0;
    int   base = 0;
    logic irq_prev = 1'b0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: samples 1 ns after each falling edge
    always @(negedge clk) begin
        exp_t it;
        #1;
        if (rst_n) begin
            if (sel && !we) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "scoreboard empty", rdata, 32'h0);
                end else begin
                    it = sb_q.pop_front();
                    check(rdata === it.exp, it.tag, rdata, it.exp);
                end
            end
            if (irq) begin
                irq_cnt++;
                if (irq_prev) check(1'b0, "R6 request wider than one clock", 32'h1, 32'h0);
            end
            irq_prev = irq;
        end
    end

    task automatic step(input logic s, input logic w, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic rt);
        @(negedge clk);
        sel = s; we = w; addr = a; wdata = d; ref_tick = rt;
        #1.5;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        step(1'b1, 1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, 1'b0, '0, 32'h0, 1'b0);
    endtask

    task automatic pulse(input int n);
        repeat (n) step(1'b0, 1'b0, '0, 32'h0, 1'b1);
    endtask

    task automatic check_irqs(input int exp, input string tag);
        check((irq_cnt - base) == exp, tag, 32'(irq_cnt - base), 32'(exp));
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(irq === 1'b0, "R1 irq low in reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;

        // R1: reset values
        rd(A_CTRL, 32'h0, "R1 ctrl reset");
        rd(A_RLD,  32'h0, "R1 reload reset");
        rd(A_CUR,  32'h0, "R1 count reset");

        // R8: reserved bits and unmapped offsets
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd(A_CTRL, 32'h0, "R8 ctrl reserved write");
        wr(A_CTRL, 32'h0001_0000);
        rd(A_CTRL, 32'h0, "R8 flag bit not writable");
        wr(A_RLD, 32'hFFFF_FFFF);
        rd(A_RLD, 32'h00FF_FFFF, "R8 reload upper bits");
        rd(8'h1C, 32'h0, "R8 unmapped offset");

        // R3/R5/R2: core clock, interrupts off, reload 5
        wr(A_CTRL, 32'h0);
        wr(A_CUR, 32'h0);
        wr(A_RLD, 32'd5);
        base = irq_cnt;
        wr(A_CTRL, 32'h5);
        idle(3);
        rd(A_CUR, 32'd4, "R3 first steps");
        rd(A_CTRL, 32'h5, "R5 flag clear mid-count");
        idle(1);
        rd(A_CTRL, 32'h5, "R5 read on expiry clock");
        rd(A_CTRL, 32'h0001_0005, "R5 set wins over read");
        rd(A_CTRL, 32'h5, "R5 cleared by read");
        rd(A_CUR, 32'd4, "R3 reload after zero");
        check_irqs(0, "R6 no request with bit1 clear");
        wr(A_CTRL, 32'h0);
        idle(3);
        rd(A_CUR, 32'd2, "R2 hold after disable");

        // R3/R6: periodic requests, reload 2
        wr(A_CUR, 32'h0);
        wr(A_RLD, 32'd2);
        base = irq_cnt;
        wr(A_CTRL, 32'h7);
        idle(14);
        check_irqs(4, "R3 period reload+1");
        rd(A_CUR, 32'd2, "R3 reload phase");

        // R4/R6/R7: reference tick source, reload 3
        wr(A_CTRL, 32'h0);
        wr(A_CUR, 32'h0);
        wr(A_RLD, 32'd3);
        base = irq_cnt;
        wr(A_CTRL, 32'h3);
        idle(4);
        rd(A_CUR, 32'd0, "R4 no steps without tick");
        pulse(1);
        rd(A_CUR, 32'd3, "R4 tick loads reload");
        idle(3);
        rd(A_CUR, 32'd3, "R4 hold between ticks");
        check_irqs(0, "R6 none before expiry");
        pulse(3);
        rd(A_CTRL, 32'h0001_0003, "R5 flag after expiry");
        check_irqs(1, "R6 single request");
        rd(A_CTRL, 32'h3, "R5 cleared by read");
        pulse(4);
        idle(1);
        check_irqs(2, "R6 second expiry");
        pulse(2);
        wr(A_CUR, 32'h0000_0123);
        rd(A_CTRL, 32'h3, "R7 write clears flag");
        rd(A_CUR, 32'd0, "R7 write zeroes count");
        check_irqs(2, "R7 no request from write");
        pulse(1);
        rd(A_CUR, 32'd3, "R7 next tick loads reload");

        // R9: zero reload parks
        wr(A_CTRL, 32'h0);
        wr(A_CUR, 32'h0);
        wr(A_RLD, 32'd0);
        base = irq_cnt;
        wr(A_CTRL, 32'h7);
        idle(10);
        rd(A_CUR, 32'd0, "R9 count parked");
        rd(A_CTRL, 32'h7, "R9 no flag");
        check_irqs(0, "R9 no request");

        idle(2);
        check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 32'h0);
        finish_run();
    end
endmodule